// File: doc/BRIEF.md
# Line Good-Signal Hysteresis Monitor

This block judges the health of a serial receive line from a single-cycle strobe that the symbol decoder raises for every symbol it cannot decode. Time is cut into fixed windows of `WIN_CYCLES` clocks. At the close of each window a small saturating level counter moves one step: up if at least one strobe arrived during the window, down if none did. The line status bit flips only when the level reaches the far end of its range, so a short burst of errors or a short clean spell does not change the verdict.

The monitor starts with the line marked bad and the level at its top value `LVL_MAX`. When the level reaches zero the line is declared good, and the level starts again from zero. When it climbs back to `LVL_MAX` the line is declared bad, and the level starts again from the top. So at least `LVL_MAX` windows are needed for a change in either direction. Each change raises a one-cycle interrupt request for the surrounding register logic.

Top module: `line_health_mon`

## Requirements
- R1: While `rst_i` is high, and in the first cycle after it falls, `line_good_o` is 0 (bad) and `line_irq_o` is 0, with the level at `LVL_MAX`.
- R2: Window n (n = 1, 2, ...) covers clock edges (n-1)*WIN_CYCLES+1 to n*WIN_CYCLES after reset release. The outputs change only at the closing edge of a window and stay unchanged at every other edge.
- R3: While the line is bad, a window with no strobe lowers the level by one, and a window with at least one strobe raises it by one, saturating at `LVL_MAX`.
- R4: While the line is bad, a window that brings the level to 0 sets `line_good_o` to 1 at that window's closing edge.
- R5: While the line is good, a window with at least one strobe raises the level by one, and a window with no strobe lowers it by one, saturating at 0.
- R6: While the line is good, a window that brings the level to `LVL_MAX` clears `line_good_o` to 0 at that window's closing edge. The level restarts at `LVL_MAX`, so `LVL_MAX` clean windows are then needed to return to good.
- R7: A strobe sampled at the closing edge of a window (the last cycle of the window) counts toward that window.
- R8: `line_irq_o` is 1 for exactly the one cycle after each edge at which `line_good_o` changes, and 0 otherwise.
- R9: Any number of strobes within one window moves the level by only one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bad_sym_i | input | 1 | One-cycle strobe per undecodable received symbol |
| line_good_o | output | 1 | Line status: 1 good, 0 bad |
| line_irq_o | output | 1 | One-cycle pulse on every status change |

## Verification
Each window verdict is due at exactly the edge numbered n*WIN_CYCLES after reset release. The status and the interrupt are both registered at that edge, so they are visible in the same cycle and no earlier. The bench drives each window as exactly WIN_CYCLES edges from the release of reset and samples one time unit after the closing edge. It also samples halfway through each window to confirm that nothing has moved yet. For the interrupt, the bench checks that it is present in the cycle after the change and gone one cycle later. For the timing of a transition, it checks that the status is still old one edge before the boundary.

// File: rtl/lhm_pkg.sv
`timescale 1ns/1ps
package lhm_pkg;

  typedef enum logic {
    LINE_BAD  = 1'b0,
    LINE_GOOD = 1'b1
  } line_state_e;

endpackage

// File: rtl/lhm_window_timer.sv
`timescale 1ns/1ps
module lhm_window_timer #(
  parameter int WIN_CYCLES = 1024
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic win_end_o
);

  localparam int CNT_W = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
  localparam bit POW2  = (WIN_CYCLES == (1 << CNT_W));

  logic [CNT_W-1:0] cnt_q;

  generate
    if (POW2) begin : g_wrap
      // power-of-two window: free-running counter wraps by itself
      always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_q + 1'b1;
      end
      assign win_end_o = &cnt_q;
    end else begin : g_cmp
      localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYCLES - 1);
      always_ff @(posedge clk_i) begin
        if (rst_i || cnt_q == LAST) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
      end
      assign win_end_o = (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/lhm_bad_latch.sv
`timescale 1ns/1ps
module lhm_bad_latch (
  input  logic clk_i,
  input  logic rst_i,
  input  logic win_end_i,
  input  logic bad_sym_i,
  output logic dirty_o
);

  logic seen_q;

  // sticky flag, cleared as each window closes
  always_ff @(posedge clk_i) begin
    if (rst_i || win_end_i) seen_q <= 1'b0;
    else if (bad_sym_i)     seen_q <= 1'b1;
  end

  // a strobe in the closing cycle still belongs to this window
  assign dirty_o = seen_q | bad_sym_i;

endmodule

// File: rtl/lhm_level_fsm.sv
`timescale 1ns/1ps
module lhm_level_fsm
  import lhm_pkg::*;
#(
  parameter int LVL_MAX = 7,
  parameter int LVL_W   = $clog2(LVL_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             win_end_i,
  input  logic             dirty_i,
  output logic [LVL_W-1:0] level_o,
  output logic             status_o,
  output logic             irq_o
);

  localparam logic [LVL_W-1:0] LVL_TOP   = LVL_W'(LVL_MAX);
  localparam logic [LVL_W-1:0] LVL_FLOOR = '0;

  line_state_e      state_q;
  logic [LVL_W-1:0] step;

  always_comb begin
    if (dirty_i) step = (level_o == LVL_TOP)   ? LVL_TOP   : level_o + 1'b1;
    else         step = (level_o == LVL_FLOOR) ? LVL_FLOOR : level_o - 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= LINE_BAD;
      level_o <= LVL_TOP;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (win_end_i) begin
        if (state_q == LINE_BAD && step == LVL_FLOOR) begin
          state_q <= LINE_GOOD;
          level_o <= LVL_FLOOR;
          irq_o   <= 1'b1;
        end else if (state_q == LINE_GOOD && step == LVL_TOP) begin
          state_q <= LINE_BAD;
          level_o <= LVL_TOP;
          irq_o   <= 1'b1;
        end else begin
          level_o <= step;
        end
      end
    end
  end

  assign status_o = (state_q == LINE_GOOD);

endmodule

// File: rtl/line_health_mon.sv
`timescale 1ns/1ps
module line_health_mon #(
  parameter int WIN_CYCLES = 1024,
  parameter int LVL_MAX    = 7,
  parameter int LVL_W      = $clog2(LVL_MAX + 1)
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic bad_sym_i,
  output logic line_good_o,
  output logic line_irq_o
);

  logic             win_end;
  logic             dirty;
  logic [LVL_W-1:0] lvl_q;

  lhm_window_timer #(
    .WIN_CYCLES(WIN_CYCLES)
  ) timer_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .win_end_o(win_end)
  );

  lhm_bad_latch latch_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .win_end_i(win_end),
    .bad_sym_i(bad_sym_i),
    .dirty_o  (dirty)
  );

  lhm_level_fsm #(
    .LVL_MAX(LVL_MAX),
    .LVL_W  (LVL_W)
  ) fsm_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .win_end_i(win_end),
    .dirty_i  (dirty),
    .level_o  (lvl_q),
    .status_o (line_good_o),
    .irq_o    (line_irq_o)
  );

endmodule

// File: rtl/lhm_checker.sv
`timescale 1ns/1ps
module lhm_checker #(
  parameter int LVL_MAX = 7,
  parameter int LVL_W   = $clog2(LVL_MAX + 1)
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             status_i,
  input logic             irq_i,
  input logic [LVL_W-1:0] level_i,
  input logic             win_end_i
);

  localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(LVL_MAX);

  AST_LEVEL_IN_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    level_i <= LVL_TOP); // R3

  AST_LEVEL_HOLD_MIDWINDOW: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(win_end_i) |-> $stable(level_i)); // R2

  AST_STATUS_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (rst_i)
    (status_i != $past(status_i)) |-> $past(win_end_i)); // R2

  AST_GOOD_ENTRY_LEVEL: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(status_i) |-> level_i == '0); // R4

  AST_BAD_ENTRY_LEVEL: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(status_i) |-> level_i == LVL_TOP); // R6

  AST_IRQ_ON_CHANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    (status_i != $past(status_i)) |-> irq_i); // R8

  AST_IRQ_ONLY_ON_CHANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_i |-> (status_i != $past(status_i))); // R8

  AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_i |=> !irq_i); // R8

endmodule

bind line_health_mon lhm_checker #(
  .LVL_MAX(LVL_MAX),
  .LVL_W  (LVL_W)
) chk_i (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .status_i (line_good_o),
  .irq_i    (line_irq_o),
  .level_i  (lvl_q),
  .win_end_i(win_end)
);

// File: tb/line_health_mon_tb_top.sv
`timescale 1ns/1ps
module line_health_mon_tb_top;

  localparam int W      = 1024;
  localparam int NVEC   = 23;
  localparam int WD_CYC = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bad = 1'b0;
  logic good, irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  line_health_mon dut_i (
    .clk_i      (clk),
    .rst_i      (rst),
    .bad_sym_i  (bad),
    .line_good_o(good),
    .line_irq_o (irq)
  );

  // {kind[1:0], expected status, expected irq}
  // kind: 0 clean, 1 one strobe mid-window, 2 strobe in last cycle only, 3 strobe every cycle
  localparam logic [3:0] VEC [0:NVEC-1] = '{
    4'b0100,                                  // R3 dirty at top: stays 7
    4'b0000, 4'b0000, 4'b0000,
    4'b0000, 4'b0000, 4'b0000,                // R3 clean: 6..1
    4'b1100,                                  // R9 many strobes: 2
    4'b0000,                                  // 1
    4'b0011,                                  // R4 reaches 0: good
    4'b0010, 4'b0010,                         // R5 saturate at 0
    4'b0110,                                  // R5 up to 1
    4'b1010,                                  // R7 last-cycle strobe: 2
    4'b0010,                                  // 1
    4'b0110, 4'b0110, 4'b0110,
    4'b0110, 4'b0110,                         // 2..6
    4'b1001,                                  // R6 R7 reaches 7: bad
    4'b0100,                                  // R6 reload 7, stays 7
    4'b0000                                   // 6
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    bad = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  // drives exactly W edges; returns 1 time unit after the closing edge
  task automatic run_window(input logic [1:0] kind);
    logic st0;
    st0 = good;
    for (int i = 0; i < W; i++) begin
      case (kind)
        2'd1:    bad = (i == W/2);
        2'd2:    bad = (i == W-1);
        2'd3:    bad = 1'b1;
        default: bad = 1'b0;
      endcase
      @(posedge clk);
      #1;
      if (i == W/2) begin
        chk("R2 status steady mid-window", good, st0);
        chk("R2 irq quiet mid-window", irq, 0);
      end
    end
    bad = 1'b0;
  endtask

  task automatic run_clean_cycles(input int n);
    bad = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    do_reset();
    chk("R1 status after reset", good, 0);
    chk("R1 irq after reset", irq, 0);

    for (int v = 0; v < NVEC; v++) begin
      string tag;
      logic [3:0] e;
      e = VEC[v];
      if (e[3:2] == 2'd2)      tag = "R7";
      else if (e[3:2] == 2'd3) tag = "R9";
      else if (e[0])           tag = e[1] ? "R4" : "R6";
      else                     tag = e[1] ? "R5" : "R3";
      run_window(e[3:2]);
      chk($sformatf("%s status vec %0d", tag, v), good, e[1]);
      chk($sformatf("R8 irq vec %0d", v), irq, e[0]);
    end

    // level now 6 in bad state: 5 more clean windows keep it bad (R6 reload)
    for (int k = 0; k < 5; k++) run_window(2'd0);
    chk("R6 still bad at level 1", good, 0);
    run_window(2'd0);
    chk("R4 good after reload climb", good, 1);
    chk("R8 irq raised", irq, 1);
    run_clean_cycles(1);
    chk("R8 irq one cycle only", irq, 0);

    // reset while good
    do_reset();
    chk("R1 status after mid-run reset", good, 0);
    chk("R1 irq after mid-run reset", irq, 0);

    // fastest rise: 7 clean windows, boundary edge exact
    for (int k = 0; k < 6; k++) run_window(2'd0);
    chk("R3 bad after six clean windows", good, 0);
    run_clean_cycles(W - 1);
    chk("R2 bad one edge before boundary", good, 0);
    chk("R2 irq low one edge before boundary", irq, 0);
    run_clean_cycles(1);
    chk("R4 good at seventh boundary", good, 1);
    chk("R8 irq at seventh boundary", irq, 1);
    run_clean_cycles(1);
    chk("R8 irq cleared", irq, 0);
    chk("R5 status held", good, 1);

    finish_run();
  end

endmodule